// File: doc/BRIEF.md
# Tournament Hybrid Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds two component predictors and a chooser. The first component is a global-history table: the branch address is XORed with a register of recent outcomes from all branches, and the result picks a 2-bit counter. The second component is a two-level local predictor. A table of per-branch histories is indexed by the branch address, and the selected history picks one counter within a pattern set that other address bits choose. A chooser table of 2-bit counters, indexed by the branch address, decides for each branch which component to trust.

A lookup is combinational. The fetch stage presents a branch address and gets back the final direction and both component guesses, and it stores both component guesses with the branch. When the branch resolves, the pipeline returns the address, the real outcome and the two stored guesses. In that cycle both components train, the local history and the global history shift, and the chooser moves if the two guesses disagreed. Histories advance only at resolve, so there is no speculative history and no repair.

Top module: `tourney_dir_pred`

## Requirements
- R1: After reset every counter holds 1 and every history is zero, so every lookup returns not-taken from the final output and from both components.
- R2: Each counter saturates between 0 and 3. A taken outcome adds one and a not-taken outcome subtracts one. A counter predicts taken when its value is 2 or 3.
- R3: The global component reads the counter at index PC[11:2] XOR GHR, where GHR is the 10-bit global history. At resolve it trains the counter at the same index formed from the resolve PC and the GHR value held before the shift.
- R4: Each resolve shifts the GHR left by one and puts the actual outcome in bit 0. The GHR does not change in a cycle without a resolve.
- R5: The local component reads the 4-bit history at entry PC[7:2] of a 64-entry history table. It then reads the counter at index {PC[5:2], history} in a 256-counter pattern table. At resolve it trains that counter and shifts the outcome into bit 0 of that history.
- R6: The final prediction equals the local guess when the chooser counter at index PC[11:2] has bit 1 clear, and equals the global guess otherwise.
- R7: The chooser counter changes only when the two returned guesses differ. It increments when the global guess equals the outcome and decrements otherwise.
- R8: A lookup changes no state. In a cycle that also resolves, the lookup outputs reflect the state before that resolve.
- R9: PC bits 1:0 affect neither lookup nor training.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | 32 | Address of the branch being looked up |
| lk_taken | output | 1 | Final direction guess |
| lk_gpred | output | 1 | Global component guess |
| lk_lpred | output | 1 | Local component guess |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome |
| res_gpred | input | 1 | Global guess saved at lookup |
| res_lpred | input | 1 | Local guess saved at lookup |

## Verification
The hardest case to reach from the ports is a chooser counter that has been driven over to the global side. That takes repeated disagreements in which the global guess wins. The global index also moves with every resolve, so the global guess cannot be set directly. The stimulus cycles several branches with fixed periodic outcome patterns, such as an alternating branch and a period-three branch, mixed with pseudo-random branches whose addresses alias in the tables. The local and global counters then split apart over time, and the chooser has to cross its midpoint in both directions. A bench model that follows the requirements predicts every lookup, including lookups made in the same cycle as a resolve.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'd1;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        nxt = cur;
        if (up && cur != 2'd3) begin
            nxt = cur + 2'd1;
        end else if (!up && cur != 2'd0) begin
            nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/tdp_ctr_table.sv
module tdp_ctr_table
    import tdp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr_t [DEPTH-1:0] cnt;
    } tab_t;

    tab_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cnt[wr_idx] = ctr_step(st_q.cnt[wr_idx], wr_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= {DEPTH{CTR_RESET}};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_ctr = st_q.cnt[rd_idx];

endmodule

// File: rtl/tdp_hist_table.sv
module tdp_hist_table #(
    parameter int IDX_W = 6,
    parameter int HW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [HW-1:0]    rd_hist,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_bit,
    output logic [HW-1:0]    wr_hist
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][HW-1:0] hist;
    } tab_t;

    tab_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.hist[wr_idx] = {st_q.hist[wr_idx][HW-2:0], wr_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_hist = st_q.hist[rd_idx];
    assign wr_hist = st_q.hist[wr_idx];

endmodule

// File: rtl/tourney_dir_pred.sv
module tourney_dir_pred
    import tdp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int PC_LSB  = 2,
    parameter int GIDX_W  = 10,
    parameter int LHT_W   = 6,
    parameter int LHIST_W = 4,
    parameter int LSET_W  = 4,
    parameter int META_W  = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic            lk_gpred,
    output logic            lk_lpred,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_gpred,
    input  logic            res_lpred
);
    localparam int PAT_W = LSET_W + LHIST_W;

    typedef struct packed {
        logic [GIDX_W-1:0] ghr;
    } top_t;

    top_t st_d, st_q;
    logic [GIDX_W-1:0] ghr_cur;

    logic [GIDX_W-1:0]  lk_gidx, res_gidx;
    logic [LHIST_W-1:0] lk_hist, res_hist;
    logic [PAT_W-1:0]   lk_pidx, res_pidx;
    ctr_t               g_ctr, l_ctr, m_ctr;
    logic               meta_wr;

    // global history register: newest outcome enters at bit 0
    always_comb begin
        st_d = st_q;
        if (res_valid) begin
            st_d.ghr = {st_q.ghr[GIDX_W-2:0], res_taken};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ghr_cur  = st_q.ghr;
    assign lk_gidx  = lk_pc[PC_LSB +: GIDX_W] ^ st_q.ghr;
    assign res_gidx = res_pc[PC_LSB +: GIDX_W] ^ st_q.ghr;
    assign lk_pidx  = {lk_pc[PC_LSB +: LSET_W], lk_hist};
    assign res_pidx = {res_pc[PC_LSB +: LSET_W], res_hist};
    assign meta_wr  = res_valid && (res_gpred != res_lpred);

    tdp_ctr_table #(.IDX_W(GIDX_W)) u_gtab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_gidx),
        .rd_ctr (g_ctr),
        .wr_en  (res_valid),
        .wr_idx (res_gidx),
        .wr_up  (res_taken)
    );

    tdp_hist_table #(.IDX_W(LHT_W), .HW(LHIST_W)) u_lht (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (lk_pc[PC_LSB +: LHT_W]),
        .rd_hist (lk_hist),
        .wr_en   (res_valid),
        .wr_idx  (res_pc[PC_LSB +: LHT_W]),
        .wr_bit  (res_taken),
        .wr_hist (res_hist)
    );

    tdp_ctr_table #(.IDX_W(PAT_W)) u_ptab (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_pidx),
        .rd_ctr (l_ctr),
        .wr_en  (res_valid),
        .wr_idx (res_pidx),
        .wr_up  (res_taken)
    );

    tdp_ctr_table #(.IDX_W(META_W)) u_meta (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (lk_pc[PC_LSB +: META_W]),
        .rd_ctr (m_ctr),
        .wr_en  (meta_wr),
        .wr_idx (res_pc[PC_LSB +: META_W]),
        .wr_up  (res_gpred == res_taken)
    );

    assign lk_gpred = g_ctr[1];
    assign lk_lpred = l_ctr[1];
    assign lk_taken = m_ctr[1] ? lk_gpred : lk_lpred;

endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
    parameter int PC_W  = 32,
    parameter int GHR_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PC_W-1:0]  lk_pc,
    input logic             lk_taken,
    input logic             lk_gpred,
    input logic             lk_lpred,
    input logic             res_valid,
    input logic             res_taken,
    input logic [GHR_W-1:0] ghr
);

    AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> ghr == {$past(ghr[GHR_W-2:0]), $past(res_taken)}); // R4

    AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(ghr)); // R4

    AST_FINAL_FROM_COMPONENT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_taken == lk_gpred) || (lk_taken == lk_lpred)); // R6

    AST_AGREE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_gpred == lk_lpred) |-> (lk_taken == lk_gpred)); // R6

    AST_LOOKUP_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> (!$stable(lk_pc) ||
                        ($stable(lk_taken) && $stable(lk_gpred) && $stable(lk_lpred)))); // R8

endmodule

bind tourney_dir_pred tdp_checker #(.PC_W(PC_W), .GHR_W(GIDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_pc     (lk_pc),
    .lk_taken  (lk_taken),
    .lk_gpred  (lk_gpred),
    .lk_lpred  (lk_lpred),
    .res_valid (res_valid),
    .res_taken (res_taken),
    .ghr       (ghr_cur)
);

// File: tb/tourney_dir_pred_test.sv
module tourney_dir_pred_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_pc, res_pc;
    logic        lk_taken, lk_gpred, lk_lpred;
    logic        res_valid, res_taken, res_gpred, res_lpred;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tourney_dir_pred uut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc),
        .lk_taken(lk_taken), .lk_gpred(lk_gpred), .lk_lpred(lk_lpred),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_gpred(res_gpred), .res_lpred(res_lpred)
    );

    // reference state built from the requirements
    logic [1:0] m_g [1024];
    logic [1:0] m_p [256];
    logic [1:0] m_m [1024];
    logic [3:0] m_h [64];
    logic [9:0] m_ghr;

    function automatic logic [1:0] step2(input logic [1:0] c, input logic up);
        if (up)  return (c == 2'd3) ? c : c + 2'd1;
        return (c == 2'd0) ? c : c - 2'd1;
    endfunction

    function automatic logic exp_g(input logic [31:0] pc);
        return m_g[pc[11:2] ^ m_ghr][1];
    endfunction

    function automatic logic exp_l(input logic [31:0] pc);
        return m_p[{pc[5:2], m_h[pc[7:2]]}][1];
    endfunction

    function automatic logic exp_f(input logic [31:0] pc);
        return m_m[pc[11:2]][1] ? exp_g(pc) : exp_l(pc);
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 1024; i++) begin m_g[i] = 2'd1; m_m[i] = 2'd1; end
        for (int i = 0; i < 256; i++) m_p[i] = 2'd1;
        for (int i = 0; i < 64; i++) m_h[i] = 4'd0;
        m_ghr = '0;
    endtask

    task automatic model_resolve(input logic [31:0] pc, input logic t,
                                 input logic gp, input logic lp);
        logic [9:0] gi;
        logic [7:0] pi;
        gi = pc[11:2] ^ m_ghr;
        m_g[gi] = step2(m_g[gi], t);
        pi = {pc[5:2], m_h[pc[7:2]]};
        m_p[pi] = step2(m_p[pi], t);
        m_h[pc[7:2]] = {m_h[pc[7:2]][2:0], t};
        if (gp != lp) m_m[pc[11:2]] = step2(m_m[pc[11:2]], gp == t);
        m_ghr = {m_ghr[8:0], t};
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b pc=%h", req, act, exp, lk_pc);
        end
    endtask

    task automatic check_lookup(input string tag);
        check({tag, " R3 global"}, lk_gpred, exp_g(lk_pc));
        check({tag, " R5 local"},  lk_lpred, exp_l(lk_pc));
        check({tag, " R6 R7 final"}, lk_taken, exp_f(lk_pc));
    endtask

    // one lookup then one resolve of the same branch; outputs sampled at negedge
    task automatic do_branch(input logic [31:0] pc, input logic t, input logic [1:0] lowbits);
        logic gp, lp;
        lk_pc = pc;
        res_valid = 1'b0;
        #1;
        check_lookup("R2");
        gp = exp_g(pc);
        lp = exp_l(pc);
        res_valid = 1'b1;
        res_pc    = {pc[31:2], lowbits};  // R9: low bits vary
        res_taken = t;
        res_gpred = gp;
        res_lpred = lp;
        #1;
        check_lookup("R8 same-cycle");
        @(posedge clk);
        model_resolve(pc, t, gp, lp);
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        rst_n = 1'b0; lk_pc = '0; res_pc = '0;
        res_valid = 1'b0; res_taken = 1'b0; res_gpred = 1'b0; res_lpred = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state over a sweep of addresses
        for (int i = 0; i < 256; i++) begin
            lk_pc = i * 52 + 32'h4000;
            #1;
            check("R1 final", lk_taken, 1'b0);
            check("R1 global", lk_gpred, 1'b0);
            check("R1 local", lk_lpred, 1'b0);
        end
        @(negedge clk);

        // R2 R4: one branch always taken, saturates; GHR fills with ones
        for (int i = 0; i < 20; i++) do_branch(32'h0000_1230, 1'b1, 2'b00);
        // alternating branch exercises local history pattern
        for (int i = 0; i < 40; i++) do_branch(32'h0000_2244, i[0], 2'b11);

        // mixed sweep: periodic and pseudo-random branches, aliasing addresses
        for (int it = 0; it < 3000; it++) begin
            int k;
            logic [31:0] pc;
            logic t;
            k = it % 6;
            lfsr = lfsr_next(lfsr);
            case (k)
                0: begin pc = 32'h0000_0100; t = 1'b1; end
                1: begin pc = 32'h0000_0204; t = (it / 6) % 2 == 0; end
                2: begin pc = 32'h0000_0308; t = (it / 6) % 3 != 2; end
                3: begin pc = 32'h0000_1104; t = ((it / 6) % 4) < 2; end  // R9: shares local set with k=1
                4: begin pc = {20'h0, lfsr[11:2], 2'b00}; t = lfsr[0]; end
                default: begin pc = 32'h0000_0500; t = !lfsr[3] || ((it / 6) % 5 == 0); end
            endcase
            do_branch(pc, t, lfsr[5:4]);
        end

        // R4: lookups with no resolve leave GHR-dependent output unchanged
        for (int i = 0; i < 64; i++) begin
            lk_pc = 32'h0000_0100 + i * 4;
            #1;
            check_lookup("R4 R8 idle");
            @(negedge clk);
        end

        // R1: reset again clears learned state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        for (int i = 0; i < 32; i++) begin
            lk_pc = 32'h0000_0100 + i * 4;
            #1;
            check("R1 re-reset", lk_taken | lk_gpred | lk_lpred, 1'b0);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule